// File: doc/BRIEF.md
# Vector Source Operand Shaper

This block prepares one 128-bit vector source operand on its way into a SIMD ALU. A 3-bit expand mode decides what happens to the two 64-bit halves of the operand. The halves can be passed through, duplicated, or exchanged. Alternatively, one half can be widened so that its narrow elements fill the full 128 bits at the current lane size, with an optional half exchange afterwards.

A 2-bit modifier field serves two purposes. For integer operations it selects how each narrow element grows into a wide lane, and it matters only when widening. For float operations it carries absolute-value and negate controls, which act on the sign bit of every lane after the half handling, in every mode.

An 8-bit swizzle is applied last. It selects, for each 32-bit quarter of the result, which quarter of the prepared value lands there. The prepared operand is registered, and appears one cycle after it is presented.

Top module: `src_operand_shaper`

## Requirements
- R1: A vector presented with `in_valid` high appears on `out_operand`, with `out_valid` high, exactly one clock later. With `in_valid` low, `out_valid` drops and `out_operand` holds its value. Reset (synchronous, active high) clears both outputs to zero.
- R2: Expand code 0 leaves the operand unchanged.
- R3: Expand code 1 copies bits [63:0] into both halves. Expand code 2 copies bits [127:64] into both halves.
- R4: Expand code 3 exchanges the two 64-bit halves.
- R5: Expand codes 4 and 5 widen the low half (code 4) or the high half (code 5). Lane size code 0/1/2/3 means 8/16/32/64-bit lanes. Narrow element k, at bits [k*L/2 +: L/2] of the chosen half, becomes lane k at bits [k*L +: L] of the result, where L is the lane width.
- R6: Expand codes 6 and 7 widen the low half (code 6) or the high half (code 7) as in R5, then exchange the two 64-bit halves of the widened value.
- R7: For integer operations, the modifier chooses the widening rule. Code 0 sign-extends. Code 1 zero-extends. Code 2 puts the narrow value in both halves of the lane. Code 3 puts it in the upper half with zeros below. Float operations (`in_float`=1) always widen by zero extension.
- R8: For integer operations with expand codes 0 to 3, the modifier has no effect on the result.
- R9: For float operations, modifier bit 0 clears the most significant bit of every lane, and bit 1 then inverts it, so both bits set gives a set sign bit. This applies in all eight expand modes, after widening and exchange.
- R10: Swizzle bits [2i+1:2i] give the source 32-bit quarter for result quarter i. The swizzle is applied after everything else, and 8'hE4 is the identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| in_operand | input | 128 | Raw source operand |
| in_expand | input | 3 | Half handling / widening mode |
| in_modifier | input | 2 | Integer widening rule, or float abs (bit 0) / neg (bit 1) |
| in_float | input | 1 | 1 = float operation, 0 = integer operation |
| in_lane_size | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| in_swizzle | input | 8 | Four 2-bit quarter selectors |
| out_valid | output | 1 | Prepared operand valid |
| out_operand | output | 128 | Prepared operand |

## Verification
The mode properties take for granted that their antecedent pins down the whole transform. They fire only when the swizzle is the identity and no float sign modifier is active, so each checks one stage in isolation. The register-hold property takes for granted that inputs may change freely while `in_valid` is low, and the stimulus drives new operand values in such cycles to make it bite. All stimulus uses only the defined encodings, and each sweep point applies its controls for a single valid cycle, which keeps every property's antecedent reachable.

// File: rtl/src_shaper_pkg.sv
package src_shaper_pkg;

    localparam int OPERAND_W   = 128;
    localparam int NUM_SIZES   = 4;
    localparam int BASE_LANE_W = 8;

    typedef enum logic [2:0] {
        XM_PASS          = 3'd0,
        XM_DUP_LO        = 3'd1,
        XM_DUP_HI        = 3'd2,
        XM_SWAP          = 3'd3,
        XM_WIDEN_LO      = 3'd4,
        XM_WIDEN_HI      = 3'd5,
        XM_WIDEN_LO_SWAP = 3'd6,
        XM_WIDEN_HI_SWAP = 3'd7
    } xmode_e;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_DUP   = 2'd2,
        EXT_SHIFT = 2'd3
    } ext_e;

    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_e;

    typedef struct packed {
        logic clear_sign;
        logic flip_sign;
    } sign_ctl_t;

    function automatic logic mode_widens(input xmode_e m);
        return (m == XM_WIDEN_LO) || (m == XM_WIDEN_HI) ||
               (m == XM_WIDEN_LO_SWAP) || (m == XM_WIDEN_HI_SWAP);
    endfunction

    function automatic logic mode_swaps_after(input xmode_e m);
        return (m == XM_WIDEN_LO_SWAP) || (m == XM_WIDEN_HI_SWAP);
    endfunction

    function automatic logic widen_takes_high(input xmode_e m);
        return (m == XM_WIDEN_HI) || (m == XM_WIDEN_HI_SWAP);
    endfunction

endpackage

// File: rtl/half_router.sv
module half_router
    import src_shaper_pkg::*;
#(
    parameter int OP_W = OPERAND_W
) (
    input  logic [OP_W-1:0]   operand,
    input  xmode_e            mode,
    output logic [OP_W-1:0]   routed,
    output logic [OP_W/2-1:0] picked
);
    localparam int HW = OP_W / 2;

    logic [HW-1:0] lo_half;
    logic [HW-1:0] hi_half;

    assign lo_half = operand[HW-1:0];
    assign hi_half = operand[OP_W-1:HW];

    always_comb begin
        unique case (mode)
            XM_DUP_LO: routed = {lo_half, lo_half};
            XM_DUP_HI: routed = {hi_half, hi_half};
            XM_SWAP:   routed = {lo_half, hi_half};
            default:   routed = operand;
        endcase
    end

    assign picked = widen_takes_high(mode) ? hi_half : lo_half;

endmodule

// File: rtl/lane_widener.sv
module lane_widener
    import src_shaper_pkg::*;
#(
    parameter int OP_W = OPERAND_W
) (
    input  logic [OP_W/2-1:0] half_in,
    input  lane_e             size,
    input  ext_e              rule,
    output logic [OP_W-1:0]   wide
);
    logic [OP_W-1:0] by_size [NUM_SIZES];

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int LW = BASE_LANE_W << s;
        localparam int NW = LW / 2;
        localparam int NL = OP_W / LW;

        logic [OP_W-1:0] grown;

        for (genvar k = 0; k < NL; k++) begin : g_lane
            logic [NW-1:0] nar;
            logic [LW-1:0] lane;

            assign nar = half_in[k*NW +: NW];

            always_comb begin
                unique case (rule)
                    EXT_SIGN:  lane = {{NW{nar[NW-1]}}, nar};
                    EXT_ZERO:  lane = {{NW{1'b0}}, nar};
                    EXT_DUP:   lane = {nar, nar};
                    default:   lane = {nar, {NW{1'b0}}};
                endcase
            end

            assign grown[k*LW +: LW] = lane;
        end

        assign by_size[s] = grown;
    end

    assign wide = by_size[size];

endmodule

// File: rtl/sign_modifier.sv
module sign_modifier
    import src_shaper_pkg::*;
#(
    parameter int OP_W = OPERAND_W
) (
    input  logic [OP_W-1:0] data_in,
    input  lane_e           size,
    input  sign_ctl_t       ctl,
    output logic [OP_W-1:0] data_out
);
    logic [OP_W-1:0] by_size [NUM_SIZES];

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int LW = BASE_LANE_W << s;
        localparam int NL = OP_W / LW;

        logic [OP_W-1:0] edited;

        for (genvar k = 0; k < NL; k++) begin : g_lane
            logic top_bit;
            assign top_bit = (data_in[k*LW + LW - 1] & ~ctl.clear_sign) ^ ctl.flip_sign;
            assign edited[k*LW +: LW] = {top_bit, data_in[k*LW +: LW-1]};
        end

        assign by_size[s] = edited;
    end

    assign data_out = by_size[size];

endmodule

// File: rtl/swizzle_xbar.sv
module swizzle_xbar #(
    parameter int OP_W  = 128,
    parameter int LANES = 4
) (
    input  logic [OP_W-1:0]                data_in,
    input  logic [LANES*$clog2(LANES)-1:0] sel,
    output logic [OP_W-1:0]                data_out
);
    localparam int SEL_W = $clog2(LANES);
    localparam int QW    = OP_W / LANES;

    logic [QW-1:0] quarter [LANES];

    for (genvar q = 0; q < LANES; q++) begin : g_split
        assign quarter[q] = data_in[q*QW +: QW];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_pick
        assign data_out[i*QW +: QW] = quarter[sel[i*SEL_W +: SEL_W]];
    end

endmodule

// File: rtl/src_operand_shaper.sv
module src_operand_shaper
    import src_shaper_pkg::*;
#(
    parameter int OP_W      = OPERAND_W,
    parameter int SWZ_LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [OP_W-1:0]       in_operand,
    input  logic [2:0]            in_expand,
    input  logic [1:0]            in_modifier,
    input  logic                  in_float,
    input  logic [1:0]            in_lane_size,
    input  logic [2*SWZ_LANES-1:0] in_swizzle,
    output logic                  out_valid,
    output logic [OP_W-1:0]       out_operand
);
    localparam int HW = OP_W / 2;

    xmode_e          mode;
    lane_e           size;
    ext_e            rule;
    sign_ctl_t       sctl;
    logic [OP_W-1:0] routed;
    logic [HW-1:0]   picked;
    logic [OP_W-1:0] wide;
    logic [OP_W-1:0] staged;
    logic [OP_W-1:0] signed_v;
    logic [OP_W-1:0] swizzled;

    assign mode = xmode_e'(in_expand);
    assign size = lane_e'(in_lane_size);
    // Float operands carry sign controls in the modifier, so widen plainly.
    assign rule = in_float ? EXT_ZERO : ext_e'(in_modifier);
    assign sctl.clear_sign = in_float & in_modifier[0];
    assign sctl.flip_sign  = in_float & in_modifier[1];

    half_router #(.OP_W(OP_W)) u_route (
        .operand (in_operand),
        .mode    (mode),
        .routed  (routed),
        .picked  (picked)
    );

    lane_widener #(.OP_W(OP_W)) u_widen (
        .half_in (picked),
        .size    (size),
        .rule    (rule),
        .wide    (wide)
    );

    always_comb begin
        if (!mode_widens(mode))
            staged = routed;
        else if (mode_swaps_after(mode))
            staged = {wide[HW-1:0], wide[OP_W-1:HW]};
        else
            staged = wide;
    end

    sign_modifier #(.OP_W(OP_W)) u_sign (
        .data_in  (staged),
        .size     (size),
        .ctl      (sctl),
        .data_out (signed_v)
    );

    swizzle_xbar #(.OP_W(OP_W), .LANES(SWZ_LANES)) u_swz (
        .data_in  (signed_v),
        .sel      (in_swizzle),
        .data_out (swizzled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_operand <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_operand <= swizzled;
        end
    end

endmodule

// File: rtl/src_operand_shaper_chk.sv
module src_operand_shaper_chk #(
    parameter int OP_W      = 128,
    parameter int SWZ_LANES = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [OP_W-1:0]        in_operand,
    input logic [2:0]             in_expand,
    input logic [1:0]             in_modifier,
    input logic                   in_float,
    input logic [1:0]             in_lane_size,
    input logic [2*SWZ_LANES-1:0] in_swizzle,
    input logic                   out_valid,
    input logic [OP_W-1:0]        out_operand
);
    localparam int HW = OP_W / 2;
    localparam int QW = OP_W / SWZ_LANES;

    logic plain;
    assign plain = in_valid && (in_swizzle == 8'hE4) && !(in_float && in_modifier != 2'd0);

    // R1
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_operand)));
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_operand == '0));
    // R2, R8
    a_r2_pass_through: assert property (@(posedge clk) disable iff (rst)
        (plain && in_expand == 3'd0) |=> out_operand == $past(in_operand));
    // R3
    a_r3_dup_low: assert property (@(posedge clk) disable iff (rst)
        (plain && in_expand == 3'd1) |=>
            (out_operand[OP_W-1:HW] == $past(in_operand[HW-1:0]) &&
             out_operand[HW-1:0]    == $past(in_operand[HW-1:0])));
    // R4
    a_r4_swap_halves: assert property (@(posedge clk) disable iff (rst)
        (plain && in_expand == 3'd3) |=>
            out_operand == {$past(in_operand[HW-1:0]), $past(in_operand[OP_W-1:HW])});
    // R9
    a_r9_neg_32: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_float && in_modifier == 2'd2 && in_expand == 3'd0 &&
         in_lane_size == 2'd2 && in_swizzle == 8'hE4) |=>
            out_operand == ($past(in_operand) ^ {SWZ_LANES{1'b1, {(QW-1){1'b0}}}}));

endmodule

bind src_operand_shaper src_operand_shaper_chk #(.OP_W(OP_W), .SWZ_LANES(SWZ_LANES)) u_chk (.*);

// File: tb/src_operand_shaper_test.sv
`timescale 1ns/1ps
module src_operand_shaper_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_operand;
    logic [2:0]   in_expand;
    logic [1:0]   in_modifier;
    logic         in_float;
    logic [1:0]   in_lane_size;
    logic [7:0]   in_swizzle;
    logic         out_valid;
    logic [127:0] out_operand;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    src_operand_shaper uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
        .in_expand(in_expand), .in_modifier(in_modifier), .in_float(in_float),
        .in_lane_size(in_lane_size), .in_swizzle(in_swizzle),
        .out_valid(out_valid), .out_operand(out_operand)
    );

    function automatic logic [127:0] model(input logic [127:0] op, input int mode,
                                           input int ext, input bit flt, input int sz,
                                           input logic [7:0] swz);
        int lw = 8 << sz;
        int nw = lw / 2;
        int nl = 128 / lw;
        logic [127:0] t, half, nmask, nar, w, s;
        logic [1:0] fm;
        fm = 2'(ext);
        nmask = (128'd1 << nw) - 128'd1;
        case (mode)
            0: t = op;
            1: t = {op[63:0], op[63:0]};
            2: t = {op[127:64], op[127:64]};
            3: t = {op[63:0], op[127:64]};
            default: begin
                half = (mode % 2 == 1) ? {64'd0, op[127:64]} : {64'd0, op[63:0]};
                t = '0;
                for (int k = 0; k < nl; k++) begin
                    nar = (half >> (k * nw)) & nmask;
                    if (flt || ext == 1) w = nar;
                    else if (ext == 0)   w = nar[nw-1] ? (nar | (nmask << nw)) : nar;
                    else if (ext == 2)   w = nar | (nar << nw);
                    else                 w = nar << nw;
                    t = t | (w << (k * lw));
                end
                if (mode >= 6) t = {t[63:0], t[127:64]};
            end
        endcase
        if (flt) begin
            for (int k = 0; k < nl; k++) begin
                if (fm[0]) t[k*lw + lw - 1] = 1'b0;
                if (fm[1]) t[k*lw + lw - 1] = ~t[k*lw + lw - 1];
            end
        end
        for (int i = 0; i < 4; i++) s[32*i +: 32] = t[32*swz[2*i +: 2] +: 32];
        return s;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [127:0] pats [3];
        logic [7:0]   swzs [3];
        logic [127:0] last;
        string        tag;
        pats[0] = 128'h0123456789ABCDEF_FEDCBA9876543210;
        pats[1] = 128'h80007FFFFF800001_C3A55A3CF00F0FF0;
        pats[2] = 128'hF1E2D3C4B5A69788_8796A5B4C3D2E1F0;
        swzs[0] = 8'hE4;
        swzs[1] = 8'h1B;
        swzs[2] = 8'h4E;

        rst = 1'b1; in_valid = 1'b0; in_operand = '1; in_expand = '0;
        in_modifier = '0; in_float = 1'b0; in_lane_size = '0; in_swizzle = 8'hE4;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", {127'd0, out_valid}, 128'd0);
        check("R1 reset data", out_operand, 128'd0);
        rst = 1'b0;

        for (int p = 0; p < 3; p++)
        for (int m = 0; m < 8; m++)
        for (int e = 0; e < 4; e++)
        for (int z = 0; z < 4; z++)
        for (int f = 0; f < 2; f++)
        for (int w = 0; w < 3; w++) begin
            in_valid = 1'b1; in_operand = pats[p]; in_expand = 3'(m);
            in_modifier = 2'(e); in_float = f[0]; in_lane_size = 2'(z);
            in_swizzle = swzs[w];
            @(negedge clk);
            if (w != 0)                          tag = "R10";
            else if (f == 1 && e != 0)           tag = "R9";
            else if (f == 0 && m < 4 && e != 0)  tag = "R8";
            else if (f == 0 && m >= 4 && e != 0) tag = "R7";
            else if (m == 0)                     tag = "R2";
            else if (m < 3)                      tag = "R3";
            else if (m == 3)                     tag = "R4";
            else if (m < 6)                      tag = "R5";
            else                                 tag = "R6";
            check(tag, out_operand, model(pats[p], m, e, f[0], z, swzs[w]));
            check("R1 valid", {127'd0, out_valid}, 128'd1);
        end

        // R1: idle cycle holds output even as inputs change
        last = out_operand;
        in_valid = 1'b0; in_operand = ~in_operand; in_expand = 3'd3;
        @(negedge clk);
        check("R1 hold data", out_operand, last);
        check("R1 idle valid", {127'd0, out_valid}, 128'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule